// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-programmed master for the two-wire PHY management interface (MDC clock, bidirectional MDIO data). A processor loads a target PHY number, a register number, a read/write selection and, for writes, a 16-bit value into small registers. It then starts a transaction by writing the control register with the start/status bit and the interface-enable bit both set. The block builds the 64-bit management frame and shifts it out on MDIO, clocked by a divided-down MDC. For reads it releases MDIO and samples the PHY's reply. It lowers the status bit when the frame is over.

The MDIO pad is modelled as three signals: an output value, an output enable and an input. The board pull-up is assumed on the input. As a result, a read from a PHY address where nothing answers returns all ones. MDC stays low while no frame is in flight. MDC runs at the system clock divided by the even parameter `CLK_DIV`. The default of 20 gives 2.5 MHz from a 50 MHz clock.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register index 0 holds the frame address: bits [4:0] are the PHY register number, bits [9:5] the PHY address (0 to 31), bit 10 the operation (1 = read, 0 = write). It reads back as written, with bits [15:11] reading 0. Index 1 holds the 16-bit write data and reads back as written. Index 2 returns the read data. Index 3 is control.
- R2: In control (index 3), bit 0 is start/status and bit 3 is interface enable. Writing bit 0 = 1 together with bit 3 = 1 starts a frame. Bit 0 reads 1 from the cycle after that write until the frame ends, then 0. Bit 3 reads back as written. All other control bits read 0.
- R3: A start written with bit 3 = 0 is ignored. Status stays 0, MDC stays low and MDIO is not driven.
- R4: A write frame is sent MSB first as 32 ones, start 01, op 01, 5-bit PHY address, 5-bit register number, turnaround 10 and 16 data bits. MDIO changes only after MDC falling edges, and the output enable is high for all 64 bits.
- R5: A read frame sends 32 ones, 01, op 10, PHY address and register number with the output enable high for those 46 bits. It then holds the enable low for the 2 turnaround bits and 16 data bits. It samples MDIO at the MDC rising edges of the data bits, MSB first. The value is in the read data register by the first cycle in which status reads 0.
- R6: A read where no PHY drives MDIO (line pulled high) returns 0xFFFF.
- R7: MDC has a period of `CLK_DIV` system clocks with equal high and low halves and is low when idle. A frame holds status at 1 for exactly 64 × `CLK_DIV` cycles and has 64 MDC rising edges.
- R8: Writes to the address or data registers during a frame change those registers but not the frame being sent. A start written during a frame is ignored and does not queue a second frame.
- R9: After reset all registers read 0, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register write strobe |
| bus_we | input | 1 | Write qualifier, must be 1 with bus_en |
| bus_idx | input | 2 | Register index (0 address, 1 write data, 2 read data, 3 control) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the indexed register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The embedded assertions check on every cycle the properties that are purely temporal. MDC is low whenever no frame is active. MDC and MDIO change only at their own divider and fall events. The master never drives MDIO on a read data sample edge. A disabled start never raises status. Every frame lasts exactly 64 × `CLK_DIV` cycles. Only the bench scenarios can show what the bits mean. Those scenarios cover the exact frame contents for chosen addresses and data, read data from a responding PHY and from an absent one, register readback, and the isolation of a frame in flight from register writes and restarts.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int HDR_BITS   = 46;  // preamble + start + op + phy + reg
  localparam int DATA_START = 48;  // first data bit position
  localparam int DATA_BITS  = 16;
  localparam int ADDR_BITS  = 5;

  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} mdio_op_e;

  // Whole frame, MSB sent first. Released positions are filled with ones.
  function automatic logic [FRAME_BITS-1:0] mdio_frame(
      mdio_op_e op, logic [ADDR_BITS-1:0] phy, logic [ADDR_BITS-1:0] regad,
      logic [DATA_BITS-1:0] data);
    logic [1:0] opc, ta;
    logic [DATA_BITS-1:0] body;
    opc  = (op == OP_READ) ? 2'b10 : 2'b01;
    ta   = (op == OP_READ) ? 2'b11 : 2'b10;
    body = (op == OP_READ) ? '1 : data;
    return {32'hFFFF_FFFF, 2'b01, opc, phy, regad, ta, body};
  endfunction

  // Master owns the line for this bit position?
  function automatic logic master_drives(mdio_op_e op, int unsigned pos);
    return (op == OP_WRITE) || (pos < HDR_BITS);
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int CLK_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          toggle;

  assign toggle   = run && (cnt == CW'(HALF - 1));
  assign rise_evt = toggle && !mdc;
  assign fall_evt = toggle && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (toggle) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: MDC moves only right after a divider event
  a_r7_mdc_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rise_evt || fall_evt) |-> $stable(mdc));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  mdio_op_e             op,
  input  logic [ADDR_BITS-1:0] phy,
  input  logic [ADDR_BITS-1:0] regad,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic                 rise_evt,
  input  logic                 fall_evt,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [DATA_BITS-1:0] rd_data
);
  localparam int POS_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [POS_W-1:0]      pos;
  mdio_op_e              op_q;
  logic [DATA_BITS-1:0]  rd_shift;
  logic                  last_fall;
  logic                  sample_now;

  assign last_fall  = busy && fall_evt && (pos == POS_W'(FRAME_BITS - 1));
  assign sample_now = busy && rise_evt && (op_q == OP_READ) &&
                      (pos >= POS_W'(DATA_START));
  assign mdio_o     = busy && shreg[FRAME_BITS-1];
  assign mdio_oe    = busy && master_drives(op_q, 32'(pos));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      shreg    <= '0;
      pos      <= '0;
      op_q     <= OP_WRITE;
      rd_shift <= '0;
      rd_data  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        shreg    <= mdio_frame(op, phy, regad, wdata);
        pos      <= '0;
        op_q     <= op;
        rd_shift <= '0;
      end
    end else begin
      if (sample_now) rd_shift <= {rd_shift[DATA_BITS-2:0], mdio_i};
      if (fall_evt) begin
        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        pos   <= pos + 1'b1;
      end
      if (last_fall) begin
        busy <= 1'b0;
        if (op_q == OP_READ) rd_data <= rd_shift;
      end
    end
  end

  // R4: the data line changes only at a falling MDC event
  a_r4_mdo_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_evt) |=> $stable(mdio_o));
  // R5: the line is released whenever read data is being sampled
  a_r5_released_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> !mdio_oe);
  // R2: status stays up until the final falling event
  a_r2_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_fall) |=> busy);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_idx,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int AREG_W = 2 * ADDR_BITS + 1;
  localparam int FRAME_CYC = FRAME_BITS * CLK_DIV;
  localparam int FC_W = $clog2(FRAME_CYC + 1);
  localparam logic [1:0] IDX_ADDR = 2'd0, IDX_WDAT = 2'd1,
                         IDX_RDAT = 2'd2, IDX_CTRL = 2'd3;

  logic [AREG_W-1:0]    addr_q;
  logic [DATA_BITS-1:0] wdat_q;
  logic                 en_q;
  logic                 busy, rise_evt, fall_evt;
  logic [DATA_BITS-1:0] rd_data;
  logic                 wr_ctrl, start_req;

  assign wr_ctrl   = bus_en && bus_we && (bus_idx == IDX_CTRL);
  assign start_req = wr_ctrl && bus_wdata[0] && bus_wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      en_q   <= 1'b0;
    end else if (bus_en && bus_we) begin
      case (bus_idx)
        IDX_ADDR: addr_q <= bus_wdata[AREG_W-1:0];
        IDX_WDAT: wdat_q <= bus_wdata;
        IDX_CTRL: en_q   <= bus_wdata[3];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (bus_idx)
      IDX_ADDR: bus_rdata = {{(16-AREG_W){1'b0}}, addr_q};
      IDX_WDAT: bus_rdata = wdat_q;
      IDX_RDAT: bus_rdata = rd_data;
      default:  bus_rdata = {12'b0, en_q, 2'b00, busy};
    endcase
  end

  mdio_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_req),
    .op(mdio_op_e'(addr_q[2*ADDR_BITS])),
    .phy(addr_q[2*ADDR_BITS-1:ADDR_BITS]), .regad(addr_q[ADDR_BITS-1:0]),
    .wdata(wdat_q), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data)
  );

  // Frame length monitor for the checks below
  logic [FC_W-1:0] busy_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cyc <= '0;
    else if (busy) busy_cyc <= busy_cyc + 1'b1;
    else           busy_cyc <= '0;
  end

  // R7: idle clock is low
  a_r7_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R7: each frame occupies exactly 64 MDC periods
  a_r7_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cyc == FC_W'(FRAME_CYC)));
  // R3: a start without enable never raises status
  a_r3_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[3] && !busy) |=> !busy);
  // R9: nothing driven while idle
  a_r9_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int DIV = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_idx = 2'd3;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #10 clk = ~clk;  // 50 MHz

  mdio_mgmt_master #(.CLK_DIV(DIV)) u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // PHY model with pull-up
  logic        phy_present = 1'b0;
  logic [15:0] phy_data = '0;
  int          rise_cnt = 0, hi_cnt = 0;
  logic [63:0] cap, oe_cap;

  function automatic logic phy_line(int k);
    if (!phy_present || k < 47 || k > 63) return 1'b1;
    if (k == 47) return 1'b0;
    return phy_data[63 - k];
  endfunction

  assign mdio_i = mdio_oe ? mdio_o : phy_line(rise_cnt);

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap[63 - rise_cnt]    <= mdio_i;
      oe_cap[63 - rise_cnt] <= mdio_oe;
    end
    rise_cnt <= rise_cnt + 1;
  end
  always @(posedge clk) if (mdc) hi_cnt <= hi_cnt + 1;

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] idx, logic [15:0] val);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_idx = idx; bus_wdata = val;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_idx = 2'd3;
  endtask

  task automatic bus_read(logic [1:0] idx, output logic [15:0] val);
    bus_idx = idx; #1; val = bus_rdata; bus_idx = 2'd3;
  endtask

  // Runs one frame; meddle writes registers and restarts mid-frame.
  task automatic run_frame(bit rd, logic [4:0] phy, logic [4:0] rg,
                           logic [15:0] data, bit meddle, output int cyc_busy);
    logic [15:0] st;
    bus_write(2'd0, {5'b0, rd, phy, rg});
    bus_write(2'd1, data);
    rise_cnt = 0; hi_cnt = 0;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_idx = 2'd3; bus_wdata = 16'h0009;
    cyc_busy = 0;
    forever begin
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_idx = 2'd3; #1;
      st = bus_rdata;
      if (st[0] == 1'b0 || cyc_busy > 5000) break;
      cyc_busy++;
      if (meddle && cyc_busy >= 100 && cyc_busy <= 102) begin
        bus_en = 1'b1; bus_we = 1'b1;
        bus_idx = 2'(cyc_busy - 100);
        if (cyc_busy == 102) bus_idx = 2'd3;
        bus_wdata = (cyc_busy == 100) ? 16'h03FF :
                    (cyc_busy == 101) ? 16'h0000 : 16'h0009;
      end
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    bus_read(2'd3, v); check("R9 ctrl after reset", v, 0);
    bus_read(2'd0, v); check("R9 addr after reset", v, 0);
    bus_read(2'd2, v); check("R9 rdata after reset", v, 0);
    check("R9 mdc/oe after reset", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    bus_write(2'd0, 16'hFDA5);
    bus_read(2'd0, v); check("R1 addr readback", v, 16'h05A5);
    bus_write(2'd1, 16'hABCD);
    bus_read(2'd1, v); check("R1 wdata readback", v, 16'hABCD);
    bus_write(2'd3, 16'h0008);
    bus_read(2'd3, v); check("R2 enable readback", v, 16'h0008);
  endtask

  task automatic t_disabled;
    logic [15:0] v;
    int moved = 0;
    rise_cnt = 0;
    bus_write(2'd3, 16'h0001);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mdc || mdio_oe) moved++;
    end
    bus_read(2'd3, v); check("R3 status with enable 0", v, 0);
    check("R3 no MDC or drive", 64'(moved + rise_cnt), 0);
  endtask

  task automatic t_write(logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    int c;
    logic [15:0] v;
    run_frame(1'b0, phy, rg, d, 1'b0, c);
    check("R4 write frame bits", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d});
    check("R4 oe held whole write", oe_cap, '1);
    check("R7 busy cycles", 64'(c), 64'(64 * DIV));
    check("R7 rising edges", 64'(rise_cnt), 64);
    check("R7 mdc high cycles", 64'(hi_cnt), 64'(32 * DIV));
    bus_read(2'd3, v); check("R2 status low after write", v, 16'h0008);
  endtask

  task automatic t_read(bit present, logic [4:0] phy, logic [4:0] rg,
                        logic [15:0] d, logic [15:0] exp);
    int c;
    logic [15:0] v;
    phy_present = present; phy_data = d;
    run_frame(1'b1, phy, rg, 16'h0000, 1'b0, c);
    bus_read(2'd2, v);
    if (present) begin
      check("R5 read data", v, exp);
      check("R5 read header bits", cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg});
      check("R5 oe release pattern", oe_cap, {{46{1'b1}}, 18'b0});
    end else begin
      check("R6 absent PHY data", v, exp);
    end
    phy_present = 1'b0;
  endtask

  task automatic t_meddle;
    int c;
    logic [15:0] v;
    run_frame(1'b0, 5'd9, 5'd3, 16'h5A0F, 1'b1, c);
    check("R8 frame unaffected", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd3, 2'b10, 16'h5A0F});
    check("R8 no extra length", 64'(c), 64'(64 * DIV));
    repeat (3 * DIV) @(negedge clk);
    bus_read(2'd3, v); check("R8 restart not queued", v, 16'h0008);
    bus_read(2'd0, v); check("R8 addr reg updated", v, 16'h03FF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs();
    t_disabled();
    bus_write(2'd3, 16'h0008);
    t_write(5'd5, 5'h11, 16'hBEEF);
    t_write(5'd31, 5'd31, 16'h0001);
    t_read(1'b1, 5'd2, 5'd1, 16'h1234, 16'h1234);
    t_read(1'b1, 5'd0, 5'd7, 16'h8001, 16'h8001);
    t_read(1'b0, 5'd31, 5'd1, 16'h0000, 16'hFFFF);
    t_meddle();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule